// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a programmable sum-of-products device: a bank of `NCELL` identical cells, each taking one sum term from the logic array and turning it into a tri-state pin (a driven value plus an enable) and a pair of feedback lines back into the array. Each cell has two configuration inputs. One chooses between a clocked path, where a D register sits between the sum term and the pin, and a direct combinational path. The other chooses whether the pin shows the selected value as is or inverted.

Feedback follows the mode. A registered cell returns its own register value, so its pin can only be an output. A combinational cell returns the value seen on the pin side of the buffer. That value is the driven data while the buffer is enabled and the external pin value while it is released, so the cell can serve as an output, an input or a bidirectional pin. The array has a reset term and a preset term that are shared by every register in the bank. The reset is asynchronous and the preset is synchronous. A preload port lets a test sequence put any chosen state into the registers. All of these act on the register contents and not on the pin level, so the pin level after a reset or preset depends on the polarity setting.

Every port is a plain level-sensitive control or data signal. No pin has a valid/ready handshake, and the bank never applies back-pressure. A new sum term is taken on every rising clock edge.

Top module: `output_macrocell`

## Requirements
- R1: With `cfg_comb[i]`=0 the cell is registered and its register takes `sum_term[i]` on each rising clock edge. With `cfg_comb[i]`=1 the pin value follows `sum_term[i]` with no clock delay.
- R2: With `cfg_true[i]`=1 `pin_out[i]` equals the selected value (register or sum term). With `cfg_true[i]`=0 it equals the inverse. This holds in both modes.
- R3: A registered cell gives `fb_true[i]` equal to its register, whatever `pin_in[i]` is. A combinational cell gives `fb_true[i]` = `pin_out[i]` when `pin_oe[i]`=1 and `pin_in[i]` when `pin_oe[i]`=0.
- R4: While `ar_term` is 1, every register holds 0, starting at once and without waiting for a clock edge.
- R5: When `sp_term` is 1 at a rising edge, every register becomes 1.
- R6: When `pl_en` is 1 at a rising edge, register i takes `pl_val[i]`. Preload wins over both preset and the sum term.
- R7: `fb_comp[i]` is always the inverse of `fb_true[i]`.
- R8: A registered cell has `pin_oe[i]` = `oe_term[i]`. A combinational cell decodes `cfg_oe_sel[2i+1:2i]`: 2'b00 gives `oe_term[i]`, 2'b01 forces the enable on, and 2'b10 or 2'b11 forces it off.
- R9: While `rst_n` is 0, every register is 0. A registered cell then shows 0 on its pin when active high and 1 when inverted.
- R10: `ar_term` wins over `pl_en` and `sp_term`. While it is 1 the registers stay 0 even if preload or preset is also asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| sum_term | input | NCELL | Sum term for each cell |
| oe_term | input | NCELL | Output-enable product term for each cell |
| ar_term | input | 1 | Shared asynchronous reset term |
| sp_term | input | 1 | Shared synchronous preset term |
| cfg_comb | input | NCELL | Mode select: 1 = combinational, 0 = registered |
| cfg_true | input | NCELL | Polarity select: 1 = active high, 0 = inverted |
| cfg_oe_sel | input | 2*NCELL | Enable source for combinational cells |
| pl_en | input | 1 | Preload strobe |
| pl_val | input | NCELL | Preload data |
| pin_in | input | NCELL | Value driven onto each pin from outside |
| pin_out | output | NCELL | Data the cell drives toward the pin |
| pin_oe | output | NCELL | Pin buffer enable |
| fb_true | output | NCELL | Feedback into the array, true polarity |
| fb_comp | output | NCELL | Feedback into the array, complement |

## Verification
The bench builds the bank with `NCELL`=4 and gives each cell a different mode and polarity. A single clock cycle therefore covers all four mode/polarity combinations, and every reset, preset or preload event shows its effect at both pin polarities at once. The two combinational cells use different enable selections, so released and driven pin feedback can be compared side by side. The same four-cell build is used for a mode swap, in which the roles of the registered and combinational cells are exchanged.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  // Enable source for a cell in combinational mode
  typedef enum logic [1:0] {
    OE_FROM_TERM = 2'b00,
    OE_FORCE_ON  = 2'b01,
    OE_FORCE_OFF = 2'b10,
    OE_OFF_SPARE = 2'b11
  } oe_sel_e;

  function automatic logic resolve_oe(input oe_sel_e sel, input logic term);
    case (sel)
      OE_FROM_TERM: return term;
      OE_FORCE_ON:  return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/olmc_state_reg.sv
module olmc_state_reg #(
  parameter int NCELL = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_term,
  input  logic             sp_term,
  input  logic             pl_en,
  input  logic [NCELL-1:0] pl_val,
  input  logic [NCELL-1:0] d,
  output logic [NCELL-1:0] q
);

  // Power-up clear and the array reset term share the asynchronous path
  logic clr;
  assign clr = ar_term | ~rst_n;

  // Priority: clear, then preload, then preset, then the sum term
  always_ff @(posedge clk or posedge clr) begin
    if (clr)          q <= '0;
    else if (pl_en)   q <= pl_val;
    else if (sp_term) q <= '1;
    else              q <= d;
  end

endmodule

// File: rtl/olmc_out_stage.sv
module olmc_out_stage
  import olmc_pkg::*;
(
  input  logic       comb_mode,
  input  logic       act_high,
  input  logic [1:0] oe_sel,
  input  logic       sum,
  input  logic       oe_pt,
  input  logic       q,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_true,
  output logic       fb_comp
);

  logic core;
  logic pad;

  always_comb begin
    core    = comb_mode ? sum : q;
    pin_out = act_high ? core : ~core;
    pin_oe  = comb_mode ? resolve_oe(oe_sel_e'(oe_sel), oe_pt) : oe_pt;
    // Pin side of the buffer: driven value when enabled, outside value otherwise
    pad     = pin_oe ? pin_out : pin_in;
    fb_true = comb_mode ? pad : q;
    fb_comp = ~fb_true;
  end

endmodule

// File: rtl/output_macrocell.sv
module output_macrocell #(
  parameter int NCELL = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCELL-1:0]   sum_term,
  input  logic [NCELL-1:0]   oe_term,
  input  logic               ar_term,
  input  logic               sp_term,
  input  logic [NCELL-1:0]   cfg_comb,
  input  logic [NCELL-1:0]   cfg_true,
  input  logic [2*NCELL-1:0] cfg_oe_sel,
  input  logic               pl_en,
  input  logic [NCELL-1:0]   pl_val,
  input  logic [NCELL-1:0]   pin_in,
  output logic [NCELL-1:0]   pin_out,
  output logic [NCELL-1:0]   pin_oe,
  output logic [NCELL-1:0]   fb_true,
  output logic [NCELL-1:0]   fb_comp
);

  localparam int SEL_W = 2;

  logic [NCELL-1:0] reg_q;

  olmc_state_reg #(.NCELL(NCELL)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .ar_term (ar_term),
    .sp_term (sp_term),
    .pl_en   (pl_en),
    .pl_val  (pl_val),
    .d       (sum_term),
    .q       (reg_q)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    olmc_out_stage u_out (
      .comb_mode (cfg_comb[i]),
      .act_high  (cfg_true[i]),
      .oe_sel    (cfg_oe_sel[SEL_W*i +: SEL_W]),
      .sum       (sum_term[i]),
      .oe_pt     (oe_term[i]),
      .q         (reg_q[i]),
      .pin_in    (pin_in[i]),
      .pin_out   (pin_out[i]),
      .pin_oe    (pin_oe[i]),
      .fb_true   (fb_true[i]),
      .fb_comp   (fb_comp[i])
    );
  end

endmodule

// File: rtl/output_macrocell_chk.sv
module output_macrocell_chk #(
  parameter int NCELL = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCELL-1:0]   sum_term,
  input logic [NCELL-1:0]   oe_term,
  input logic               ar_term,
  input logic               sp_term,
  input logic [NCELL-1:0]   cfg_comb,
  input logic [2*NCELL-1:0] cfg_oe_sel,
  input logic               pl_en,
  input logic [NCELL-1:0]   pl_val,
  input logic [NCELL-1:0]   pin_oe,
  input logic [NCELL-1:0]   fb_true
);

  for (genvar i = 0; i < NCELL; i++) begin : g_chk
    // R4 / R10: reset term holds every registered cell at 0
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_term && !cfg_comb[i]) |-> !fb_true[i]);

    // R5: preset without preload or reset sets the register
    assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_term && !pl_en && !ar_term) |=> (cfg_comb[i] || ar_term || fb_true[i]));

    // R6: preload value lands in the register
    assert_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pl_en && !ar_term) |=> (cfg_comb[i] || ar_term || fb_true[i] == $past(pl_val[i])));

    // R1: normal capture of the sum term
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pl_en && !sp_term && !ar_term) |=>
        (cfg_comb[i] || ar_term || fb_true[i] == $past(sum_term[i])));

    // R8: enable source in both modes
    assert_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_comb[i] || cfg_oe_sel[2*i +: 2] == 2'b00) |-> (pin_oe[i] == oe_term[i]));
  end

endmodule

bind output_macrocell output_macrocell_chk #(.NCELL(NCELL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sum_term   (sum_term),
  .oe_term    (oe_term),
  .ar_term    (ar_term),
  .sp_term    (sp_term),
  .cfg_comb   (cfg_comb),
  .cfg_oe_sel (cfg_oe_sel),
  .pl_en      (pl_en),
  .pl_val     (pl_val),
  .pin_oe     (pin_oe),
  .fb_true    (fb_true)
);

// File: tb/output_macrocell_bench.sv
`timescale 1ns/100ps
module output_macrocell_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, ar_term, sp_term, pl_en;
  logic [N-1:0]   sum_term, oe_term, cfg_comb, cfg_true, pl_val, pin_in;
  logic [2*N-1:0] cfg_oe_sel;
  logic [N-1:0]   pin_out, pin_oe, fb_true, fb_comp;

  // staged stimulus, applied on the falling edge
  logic           s_rst_n, s_ar, s_sp, s_pl;
  logic [N-1:0]   s_sum, s_oept, s_comb, s_true, s_plv, s_pin;
  logic [2*N-1:0] s_sel;

  output_macrocell #(.NCELL(N)) u_output_macrocell (
    .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
    .ar_term(ar_term), .sp_term(sp_term), .cfg_comb(cfg_comb), .cfg_true(cfg_true),
    .cfg_oe_sel(cfg_oe_sel), .pl_en(pl_en), .pl_val(pl_val), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] out;
    logic [N-1:0] oe;
    logic [N-1:0] fb;
  } exp_t;

  exp_t         sb[$];
  logic [N-1:0] mq;
  int           checks = 0;
  int           errors = 0;
  bit           ended  = 0;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: apply staged inputs, advance the model, push the expectation
  task automatic go(string tag);
    exp_t e;
    logic core, pad;
    logic [1:0] sel;
    @(negedge clk);
    rst_n = s_rst_n; ar_term = s_ar; sp_term = s_sp; pl_en = s_pl;
    sum_term = s_sum; oe_term = s_oept; cfg_comb = s_comb; cfg_true = s_true;
    pl_val = s_plv; pin_in = s_pin; cfg_oe_sel = s_sel;
    if (!s_rst_n || s_ar) mq = '0;
    else if (s_pl)        mq = s_plv;
    else if (s_sp)        mq = '1;
    else                  mq = s_sum;
    for (int i = 0; i < N; i++) begin
      core = s_comb[i] ? s_sum[i] : mq[i];
      e.out[i] = s_true[i] ? core : ~core;
      sel = s_sel[2*i +: 2];
      e.oe[i] = s_comb[i] ? ((sel == 2'b00) ? s_oept[i] : (sel == 2'b01)) : s_oept[i];
      pad = e.oe[i] ? e.out[i] : s_pin[i];
      e.fb[i] = s_comb[i] ? pad : mq[i];
    end
    e.tag = tag;
    sb.push_back(e);
    if (s_ar && s_rst_n) begin
      #0.5;
      chk("R4 immediate clear", fb_true & ~s_comb, '0);
    end
  endtask

  // monitor: compare one expectation per cycle, after the edge settles
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk({e.tag, " pin_out"}, pin_out, e.out);
        chk({e.tag, " pin_oe"},  pin_oe,  e.oe);
        chk({e.tag, " fb_true"}, fb_true, e.fb);
        chk({e.tag, " R7 fb_comp"}, fb_comp, ~e.fb);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    s_rst_n = 0; s_ar = 0; s_sp = 0; s_pl = 0; s_plv = '0;
    s_sum = '0; s_oept = 4'b1111; s_pin = 4'b1010;
    s_comb = 4'b1100;              // cells 0,1 registered; 2,3 combinational
    s_true = 4'b0101;              // cells 0,2 active high; 1,3 inverted
    s_sel  = {2'b01, 2'b00, 2'b00, 2'b00};
    rst_n = 0; ar_term = 0; sp_term = 0; pl_en = 0; sum_term = '0; oe_term = '0;
    cfg_comb = '0; cfg_true = '0; pl_val = '0; pin_in = '0; cfg_oe_sel = '0;

    go("R9 reset state");
    go("R9 reset held");
    s_rst_n = 1; s_sum = 4'b0011; go("R1 capture");
    s_sum = 4'b1100; s_pin = 4'b0101; go("R3 reg pin ignored");
    s_sum = 4'b1010; go("R2 polarity");
    s_sp = 1; go("R5 preset");
    s_sp = 0; s_sum = 4'b0000; go("R1 after preset");
    s_pl = 1; s_plv = 4'b0010; s_sp = 1; go("R6 preload over preset");
    s_pl = 0; s_sp = 0; s_sum = 4'b0001; go("R1 resume");
    s_pl = 1; s_plv = 4'b0001; s_sum = 4'b0010; go("R6 preload over D");
    s_pl = 0; s_sum = 4'b0011; go("R1 set");
    s_ar = 1; s_pl = 1; s_plv = '1; s_sp = 1; go("R10 reset priority");
    go("R10 reset held");
    s_ar = 0; s_pl = 0; s_sp = 0; go("R4 release");
    s_oept = 4'b0000; go("R8 term low, R3 pad");
    s_pin = 4'b1000; s_sel = {2'b10, 2'b00, 2'b00, 2'b00}; go("R8 forced off");
    s_pin = 4'b0000; s_sel = {2'b11, 2'b00, 2'b00, 2'b00}; go("R8 spare off");
    s_oept = 4'b1000; s_sel = '0; s_sum = 4'b1001; go("R8 term high");
    s_comb = 4'b0011; s_sum = 4'b0110; s_oept = 4'b1111; go("R1 mode swap");
    s_sum = 4'b1001; go("R2 mode swap");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule